// File: doc/BRIEF.md
# Super I/O Configuration Unlock Sequencer

This block is the configuration front end of a multifunction PC I/O controller on an 8-bit ISA-style I/O bus. It watches byte writes to two fixed key ports and detects a five-write unlock sequence. The fourth write of the sequence carries an address byte, and the fifth write must be its bitwise complement. When the complement matches, the block opens an index/data port pair at the address byte shifted left by two. While the pair is open, software selects one of sixteen indexes and reads or writes fifteen byte registers. A data write at the last index closes the pair again.

The block drives the resource settings for four peripheral functions: an RTC, two UARTs, a parallel port and a game port. These settings are decoded enables, base addresses and IRQ numbers. They are taken from the registers only at reset and at the moment the pair closes. While the pair is open, every enable is held low and the bases and IRQs keep their last applied values.

A parameter picks one of two unlock keys. In the fixed key, the opening bytes are constants. In the paired key, the first byte may be any value other than 0x00 and 0xFF, and the second byte must complement it. The two keys also load different power-on register defaults.

Top module: `sio_cfg_unlock`

## Requirements
- R1: After reset with VARIANT=1 (the default), the registers hold reg0=0x00, reg3=0xB0, reg4=0xFE, reg5=0xBE, reg6=0x9E, reg7=0x80 and reg8=0xEC, and the outputs are decoded from them. So every function enable is 0, rtcEn is 1, and the bases are RTC 0x2C0, UART1 0x3F8, UART2 0x2F8, parallel port 0x278 and game port 0x200. The IRQs are UART1 4, UART2 3 and parallel port 5, and the RTC IRQ is 0xFF. With VARIANT=0, the defaults are reg0=0x0C, reg4=0xFE, reg6=0x9E, reg9=0xB0 and reg12=0xA0, with every other register 0.
- R2: With VARIANT=1, the unlock sequence is five writes, in this order:
  - a byte K to 0x2FA, where K is neither 0x00 nor 0xFF;
  - a byte to 0x3FA whose OR with K is 0xFF;
  - 0x36 to 0x3FA;
  - an address byte A to 0x3FA;
  - a byte to 0x2FA whose OR with A is 0xFF.

  After the fifth write, configuration mode is on, the index port is at A*4 and the data port is at A*4+1.
- R3: With VARIANT=0, the first two writes of the sequence are 0x55 to 0x2FA and then 0xAA to 0x3FA. The remaining three writes are the same as in R2.
- R4: Any write to 0x2FA or 0x3FA that does not match the expected step restarts the sequence at the first step. A fifth write that fails the complement check leaves configuration mode off.
- R5: In configuration mode, a write to the index port stores bits 3:0 of the byte, and a read of the index port returns that index in bits 3:0 with bits 7:4 zero. A read of any address, when it is not an open index or data port, returns 0xFF.
- R6: In configuration mode, a data-port write at an index from 0 to 14 stores the byte in that register. A data-port read at such an index returns the stored byte. A data-port read at index 15 returns the address byte A.
- R7: A data-port write at index 15 turns configuration mode off. The registers keep their values through any later unlock sequence.
- R8: While configuration mode is on, all enables are 0, including rtcEn. The base and IRQ outputs keep their last applied values.
- R9: When configuration mode turns off, the enables are taken from reg0: bit0 is the game port, bit1 UART1, bit2 UART2 and bit3 the parallel port. The bases are the register value times 4, using reg3 for the RTC, reg4 for UART1, reg5 for UART2, reg6 for the parallel port and reg7 for the game port. rtcEn returns to 1.
- R10: reg8 routes interrupts through four 2-bit fields:
  - bits 7:6 drive IRQ 3, where 01 selects the RTC, 10 UART1 and 11 UART2;
  - bits 5:4 drive IRQ 4, with the same codes as bits 7:6;
  - bits 3:2 drive IRQ 5, where 01 selects the RTC, 10 UART1 and 11 the parallel port;
  - bits 1:0 drive IRQ 7, where 01 selects the RTC, 10 UART2 and 11 the parallel port.

  A field value of 00 routes nothing. A function that no field selects reports IRQ 0xFF. If several fields select the same function, the function takes the highest IRQ among them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioWr | input | 1 | I/O write strobe, one cycle per byte |
| ioRd | input | 1 | I/O read strobe |
| ioAddr | input | ADDR_W | I/O address |
| ioWdata | input | 8 | Write byte |
| ioRdata | output | 8 | Read byte, valid in the same cycle as ioRd |
| rtcEn | output | 1 | RTC decode enable |
| gameEn | output | 1 | Game port enable |
| uart1En | output | 1 | UART1 enable |
| uart2En | output | 1 | UART2 enable |
| lptEn | output | 1 | Parallel port enable |
| rtcBase | output | ADDR_W | RTC base address |
| uart1Base | output | ADDR_W | UART1 base address |
| uart2Base | output | ADDR_W | UART2 base address |
| lptBase | output | ADDR_W | Parallel port base address |
| gameBase | output | ADDR_W | Game port base address |
| rtcIrq | output | 8 | RTC IRQ number, 0xFF for none |
| uart1Irq | output | 8 | UART1 IRQ number, 0xFF for none |
| uart2Irq | output | 8 | UART2 IRQ number, 0xFF for none |
| lptIrq | output | 8 | Parallel port IRQ number, 0xFF for none |

## Verification
Read data comes from a combinational path, so it is due in the same cycle as the read strobe. A write is taken at the rising edge that ends its cycle. The fifth unlock write and the closing write at index 15 change the enables, bases and IRQs just after that same edge, because those outputs come from a single register stage. The reference model in the bench advances on each rising edge from the bus inputs it drove. The bench compares every output against that model on the following falling edge, when both the inputs and the registered state are settled. Directed checks also sample at a falling edge, after the write that should have changed the result.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int IDX_W    = 4;
  localparam int NUM_REGS = (1 << IDX_W) - 1;
  localparam logic [IDX_W-1:0] LOCK_IDX = IDX_W'(NUM_REGS);
  localparam logic [7:0] NO_IRQ = 8'hFF;

  typedef struct packed {
    logic             regWr;
    logic             apply;
    logic [IDX_W-1:0] regIdx;
    logic [7:0]       regData;
  } cfgStrobe_t;

  typedef struct packed {
    logic       gameEn;
    logic       uart1En;
    logic       uart2En;
    logic       lptEn;
    logic [7:0] rtcPage;
    logic [7:0] uart1Page;
    logic [7:0] uart2Page;
    logic [7:0] lptPage;
    logic [7:0] gamePage;
    logic [7:0] rtcIrq;
    logic [7:0] uart1Irq;
    logic [7:0] uart2Irq;
    logic [7:0] lptIrq;
  } resource_t;

  function automatic logic [7:0] defaultReg(input int variant, input int i);
    logic [7:0] v;
    v = 8'h00;
    if (variant != 0) begin
      case (i)
        3: v = 8'hB0;
        4: v = 8'hFE;
        5: v = 8'hBE;
        6: v = 8'h9E;
        7: v = 8'h80;
        8: v = 8'hEC;
        default: v = 8'h00;
      endcase
    end else begin
      case (i)
        0: v = 8'h0C;
        4: v = 8'hFE;
        6: v = 8'h9E;
        9: v = 8'hB0;
        12: v = 8'hA0;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

  // Fields are taken in ascending IRQ order so the higher IRQ overrides.
  function automatic resource_t decodeRes(input logic [7:0] en, input logic [7:0] rtcB,
                                          input logic [7:0] u1B, input logic [7:0] u2B,
                                          input logic [7:0] lptB, input logic [7:0] gameB,
                                          input logic [7:0] route);
    resource_t r;
    r.gameEn    = en[0];
    r.uart1En   = en[1];
    r.uart2En   = en[2];
    r.lptEn     = en[3];
    r.rtcPage   = rtcB;
    r.uart1Page = u1B;
    r.uart2Page = u2B;
    r.lptPage   = lptB;
    r.gamePage  = gameB;
    r.rtcIrq    = NO_IRQ;
    r.uart1Irq  = NO_IRQ;
    r.uart2Irq  = NO_IRQ;
    r.lptIrq    = NO_IRQ;
    case (route[7:6])
      2'd1: r.rtcIrq = 8'd3;
      2'd2: r.uart1Irq = 8'd3;
      2'd3: r.uart2Irq = 8'd3;
      default: ;
    endcase
    case (route[5:4])
      2'd1: r.rtcIrq = 8'd4;
      2'd2: r.uart1Irq = 8'd4;
      2'd3: r.uart2Irq = 8'd4;
      default: ;
    endcase
    case (route[3:2])
      2'd1: r.rtcIrq = 8'd5;
      2'd2: r.uart1Irq = 8'd5;
      2'd3: r.lptIrq = 8'd5;
      default: ;
    endcase
    case (route[1:0])
      2'd1: r.rtcIrq = 8'd7;
      2'd2: r.uart2Irq = 8'd7;
      2'd3: r.lptIrq = 8'd7;
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VARIANT = 1,
  parameter logic [ADDR_W-1:0] KEY_PORT_A = ADDR_W'(16'h02FA),
  parameter logic [ADDR_W-1:0] KEY_PORT_B = ADDR_W'(16'h03FA)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWdata,
  input  logic [7:0]        regRdata,
  output logic [7:0]        ioRdata,
  output logic              cfgMode,
  output cfgStrobe_t        strb
);
  localparam int PAD_W = ADDR_W - 10;
  localparam logic [2:0] LAST_STEP = 3'd4;

  logic [2:0]       step;
  logic [7:0]       keyByte;
  logic [7:0]       cfgByte;
  logic [IDX_W-1:0] idx;
  logic             wrA, wrB, stepHit, idxHit, dataHit;
  logic [ADDR_W-1:0] idxPort, dataPort;

  assign wrA      = ioWr && (ioAddr == KEY_PORT_A);
  assign wrB      = ioWr && (ioAddr == KEY_PORT_B);
  assign idxPort  = {{PAD_W{1'b0}}, cfgByte, 2'b00};
  assign dataPort = {{PAD_W{1'b0}}, cfgByte, 2'b01};
  assign idxHit   = cfgMode && (ioAddr == idxPort);
  assign dataHit  = cfgMode && (ioAddr == dataPort);

  always_comb begin
    stepHit = 1'b0;
    case (step)
      3'd0: stepHit = wrA && ((VARIANT != 0) ? (ioWdata != 8'h00 && ioWdata != 8'hFF)
                                             : (ioWdata == 8'h55));
      3'd1: stepHit = wrB && ((VARIANT != 0) ? ((ioWdata | keyByte) == 8'hFF)
                                             : (ioWdata == 8'hAA));
      3'd2: stepHit = wrB && (ioWdata == 8'h36);
      3'd3: stepHit = wrB;
      default: stepHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step    <= 3'd0;
      keyByte <= 8'h00;
      cfgByte <= 8'h00;
      idx     <= '0;
      cfgMode <= 1'b0;
    end else begin
      if (wrA || wrB) step <= stepHit ? step + 3'd1 : 3'd0;
      if ((step == 3'd0 && stepHit && VARIANT != 0) || (step == 3'd3 && stepHit))
        keyByte <= ioWdata;
      if (wrA && step == LAST_STEP) begin
        if ((ioWdata | keyByte) == 8'hFF) begin
          cfgMode <= 1'b1;
          cfgByte <= keyByte;
        end else begin
          cfgMode <= 1'b0;
        end
      end
      if (ioWr && idxHit) idx <= ioWdata[IDX_W-1:0];
      if (ioWr && dataHit && idx == LOCK_IDX) cfgMode <= 1'b0;
    end
  end

  always_comb begin
    strb.regWr   = ioWr && dataHit && (idx != LOCK_IDX);
    strb.apply   = ioWr && dataHit && (idx == LOCK_IDX);
    strb.regIdx  = idx;
    strb.regData = ioWdata;
  end

  always_comb begin
    ioRdata = 8'hFF;
    if (ioRd && idxHit)       ioRdata = {{(8-IDX_W){1'b0}}, idx};
    else if (ioRd && dataHit) ioRdata = (idx == LOCK_IDX) ? cfgByte : regRdata;
  end

  // R2
  enter_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgMode) |-> $past(step) == LAST_STEP);
  // R4
  step_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrA || wrB) && !stepHit |=> step == 3'd0);
  // R7
  lock_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioWr && dataHit && idx == LOCK_IDX && !(wrA && step == LAST_STEP) |=> !cfgMode);
  // R5
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioRd && !cfgMode |-> ioRdata == 8'hFF);
endmodule

// File: rtl/sio_cfg_datapath.sv
module sio_cfg_datapath
  import sio_cfg_pkg::*;
#(
  parameter int VARIANT = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strb,
  output logic [7:0] regRdata,
  output resource_t  active
);
  logic [7:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[i] <= defaultReg(VARIANT, i);
      else if (strb.regWr && strb.regIdx == IDX_W'(i)) regs[i] <= strb.regData;
    end
  end

  always_comb begin
    regRdata = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (strb.regIdx == IDX_W'(i)) regRdata = regs[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      active <= decodeRes(defaultReg(VARIANT, 0), defaultReg(VARIANT, 3), defaultReg(VARIANT, 4),
                          defaultReg(VARIANT, 5), defaultReg(VARIANT, 6), defaultReg(VARIANT, 7),
                          defaultReg(VARIANT, 8));
    else if (strb.apply)
      active <= decodeRes(regs[0], regs[3], regs[4], regs[5], regs[6], regs[7], regs[8]);
  end

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.apply |=> $stable(active));
  // R10
  irq_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active.rtcIrq == NO_IRQ || (active.rtcIrq != active.uart1Irq &&
      active.rtcIrq != active.uart2Irq && active.rtcIrq != active.lptIrq)) &&
    (active.uart1Irq == NO_IRQ || (active.uart1Irq != active.uart2Irq &&
      active.uart1Irq != active.lptIrq)) &&
    (active.uart2Irq == NO_IRQ || active.uart2Irq != active.lptIrq));
endmodule

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VARIANT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  output logic              rtcEn,
  output logic              gameEn,
  output logic              uart1En,
  output logic              uart2En,
  output logic              lptEn,
  output logic [ADDR_W-1:0] rtcBase,
  output logic [ADDR_W-1:0] uart1Base,
  output logic [ADDR_W-1:0] uart2Base,
  output logic [ADDR_W-1:0] lptBase,
  output logic [ADDR_W-1:0] gameBase,
  output logic [7:0]        rtcIrq,
  output logic [7:0]        uart1Irq,
  output logic [7:0]        uart2Irq,
  output logic [7:0]        lptIrq
);
  localparam int PAD_W = ADDR_W - 10;

  cfgStrobe_t strb;
  resource_t  active;
  logic [7:0] regRdata;
  logic       cfgMode;

  sio_cfg_ctrl #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .regRdata(regRdata), .ioRdata(ioRdata),
    .cfgMode(cfgMode), .strb(strb));

  sio_cfg_datapath #(.VARIANT(VARIANT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regRdata(regRdata), .active(active));

  assign rtcEn     = !cfgMode;
  assign gameEn    = active.gameEn  && !cfgMode;
  assign uart1En   = active.uart1En && !cfgMode;
  assign uart2En   = active.uart2En && !cfgMode;
  assign lptEn     = active.lptEn   && !cfgMode;
  assign rtcBase   = {{PAD_W{1'b0}}, active.rtcPage,   2'b00};
  assign uart1Base = {{PAD_W{1'b0}}, active.uart1Page, 2'b00};
  assign uart2Base = {{PAD_W{1'b0}}, active.uart2Page, 2'b00};
  assign lptBase   = {{PAD_W{1'b0}}, active.lptPage,   2'b00};
  assign gameBase  = {{PAD_W{1'b0}}, active.gamePage,  2'b00};
  assign rtcIrq    = active.rtcIrq;
  assign uart1Irq  = active.uart1Irq;
  assign uart2Irq  = active.uart2Irq;
  assign lptIrq    = active.lptIrq;
endmodule

// File: tb/tb_sio_cfg_unlock.sv
module tb_sio_cfg_unlock;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioWr = 1'b0, ioRd = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic [7:0]  ioWdata = 8'h0;

  logic [7:0]  rd [2];
  logic        enR [2], enG [2], enU1 [2], enU2 [2], enL [2];
  logic [15:0] bR [2], bU1 [2], bU2 [2], bL [2], bG [2];
  logic [7:0]  iR [2], iU1 [2], iU2 [2], iL [2];

  int nChk = 0, nFail = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_unlock #(.VARIANT(0)) dut0 (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ioRdata(rd[0]), .rtcEn(enR[0]), .gameEn(enG[0]), .uart1En(enU1[0]), .uart2En(enU2[0]),
    .lptEn(enL[0]), .rtcBase(bR[0]), .uart1Base(bU1[0]), .uart2Base(bU2[0]), .lptBase(bL[0]),
    .gameBase(bG[0]), .rtcIrq(iR[0]), .uart1Irq(iU1[0]), .uart2Irq(iU2[0]), .lptIrq(iL[0]));

  sio_cfg_unlock #(.VARIANT(1)) dut (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ioRdata(rd[1]), .rtcEn(enR[1]), .gameEn(enG[1]), .uart1En(enU1[1]), .uart2En(enU2[1]),
    .lptEn(enL[1]), .rtcBase(bR[1]), .uart1Base(bU1[1]), .uart2Base(bU2[1]), .lptBase(bL[1]),
    .gameBase(bG[1]), .rtcIrq(iR[1]), .uart1Irq(iU1[1]), .uart2Irq(iU2[1]), .lptIrq(iL[1]));

  // Behavioural reference model, index 0 = fixed key, 1 = paired key
  int mSt [2], mLat [2], mCfg [2], mPage [2], mIdx [2];
  int mReg [2][15];
  int aEn [2];
  int aPage [2][5];   // rtc, uart1, uart2, lpt, game
  int aIrq [2][4];    // rtc, uart1, uart2, lpt

  task automatic modelApply(input int v);
    int slots [4] = '{3, 4, 5, 7};
    aEn[v] = mReg[v][0] & 15;
    for (int k = 0; k < 5; k++) aPage[v][k] = mReg[v][3 + k];
    for (int k = 0; k < 4; k++) aIrq[v][k] = 255;
    for (int k = 0; k < 4; k++) begin
      int f, who;
      f = (mReg[v][8] >> (6 - 2 * k)) & 3;
      who = -1;
      if (f == 1) who = 0;
      else if (f == 2) who = (k == 3) ? 2 : 1;
      else if (f == 3) who = (k >= 2) ? 3 : 2;
      if (who >= 0) aIrq[v][who] = slots[k];
    end
  endtask

  task automatic modelReset(input int v);
    for (int i = 0; i < 15; i++) mReg[v][i] = 0;
    if (v == 1) begin
      mReg[v][3] = 'hB0; mReg[v][4] = 'hFE; mReg[v][5] = 'hBE;
      mReg[v][6] = 'h9E; mReg[v][7] = 'h80; mReg[v][8] = 'hEC;
    end else begin
      mReg[v][0] = 'h0C; mReg[v][4] = 'hFE; mReg[v][6] = 'h9E;
      mReg[v][9] = 'hB0; mReg[v][12] = 'hA0;
    end
    mSt[v] = 0; mLat[v] = 0; mCfg[v] = 0; mPage[v] = 0; mIdx[v] = 0;
    modelApply(v);
  endtask

  task automatic modelWrite(input int v, input int a, input int d);
    int oldCfg, oldPage, hit;
    oldCfg = mCfg[v]; oldPage = mPage[v]; hit = 0;
    if (a == 'h2FA) begin
      if (mSt[v] == 0 && ((v == 1) ? (d != 0 && d != 255) : (d == 'h55))) begin
        hit = 1;
        if (v == 1) mLat[v] = d;
      end else if (mSt[v] == 4) begin
        if ((d | mLat[v]) == 255) begin mCfg[v] = 1; mPage[v] = mLat[v]; end
        else mCfg[v] = 0;
      end
    end else if (a == 'h3FA) begin
      if (mSt[v] == 1 && ((v == 1) ? ((d | mLat[v]) == 255) : (d == 'hAA))) hit = 1;
      else if (mSt[v] == 2 && d == 'h36) hit = 1;
      else if (mSt[v] == 3) begin mLat[v] = d; hit = 1; end
    end
    if (a == 'h2FA || a == 'h3FA) mSt[v] = hit ? mSt[v] + 1 : 0;
    if (oldCfg != 0 && a == oldPage * 4) mIdx[v] = d & 15;
    else if (oldCfg != 0 && a == oldPage * 4 + 1) begin
      if (mIdx[v] == 15) begin mCfg[v] = 0; modelApply(v); end
      else mReg[v][mIdx[v]] = d;
    end
  endtask

  function automatic int modelRead(input int v, input int a);
    if (mCfg[v] != 0 && a == mPage[v] * 4) return mIdx[v];
    if (mCfg[v] != 0 && a == mPage[v] * 4 + 1) return (mIdx[v] == 15) ? mPage[v] : mReg[v][mIdx[v]];
    return 255;
  endfunction

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (!rstN) modelReset(v);
      else if (ioWr) modelWrite(v, int'(ioAddr), int'(ioWdata));
    end
    started = 1;
  end

  task automatic chk(input int act, input int exp, input string tag);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (started && rstN) begin
      for (int v = 0; v < 2; v++) begin
        int en;
        en = (mCfg[v] != 0) ? 0 : aEn[v];
        chk(enR[v], (mCfg[v] != 0) ? 0 : 1, "R8 rtcEn vs model");
        chk({enL[v], enU2[v], enU1[v], enG[v]}, en, "R9 enables vs model");
        chk(bR[v], aPage[v][0] * 4, "R9 rtc base vs model");
        chk(bU1[v], aPage[v][1] * 4, "R9 uart1 base vs model");
        chk(bU2[v], aPage[v][2] * 4, "R9 uart2 base vs model");
        chk(bL[v], aPage[v][3] * 4, "R9 lpt base vs model");
        chk(bG[v], aPage[v][4] * 4, "R9 game base vs model");
        chk(iR[v], aIrq[v][0], "R10 rtc irq vs model");
        chk(iU1[v], aIrq[v][1], "R10 uart1 irq vs model");
        chk(iU2[v], aIrq[v][2], "R10 uart2 irq vs model");
        chk(iL[v], aIrq[v][3], "R10 lpt irq vs model");
        chk(rd[v], ioRd ? modelRead(v, int'(ioAddr)) : 255, "R6 read data vs model");
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    ioWr = 1'b1; ioAddr = a; ioWdata = d;
    @(negedge clk); #1;
    ioWr = 1'b0;
  endtask

  task automatic rdv(input logic [15:0] a, input int v, output int val);
    ioRd = 1'b1; ioAddr = a;
    @(negedge clk);
    val = rd[v];
    #1 ioRd = 1'b0;
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int val;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(bU1[1], 'h3F8, "R1 uart1 base default");
    chk(bU2[1], 'h2F8, "R1 uart2 base default");
    chk(iU1[1], 4, "R1 uart1 irq default");
    chk(iU2[1], 3, "R1 uart2 irq default");
    chk(iL[1], 5, "R1 lpt irq default");
    chk(iR[1], 'hFF, "R1 rtc irq default");
    chk(enL[0], 1, "R1 fixed-key lpt enable default");
    chk(enU1[1], 0, "R1 uart1 enable default");
    // R5 read while locked
    rdv(16'h00F0, 1, val); chk(val, 'hFF, "R5 locked read");
    // R2 paired-key unlock, address byte 0x3C -> ports 0xF0/0xF1
    wr(16'h02FA, 8'h0F); wr(16'h03FA, 8'hF0); wr(16'h03FA, 8'h36);
    wr(16'h03FA, 8'h3C); wr(16'h02FA, 8'hC3);
    chk(enR[1], 0, "R2 unlocked (rtcEn low)");
    chk(enR[0], 1, "R3 fixed key ignores paired bytes");
    wr(16'h00F0, 8'h1F);
    rdv(16'h00F1, 1, val); chk(val, 'h3C, "R6 index15 read");
    wr(16'h00F0, 8'h04); wr(16'h00F1, 8'h5F);
    rdv(16'h00F1, 1, val); chk(val, 'h5F, "R6 reg4 readback");
    wr(16'h00F0, 8'h17);
    rdv(16'h00F0, 1, val); chk(val, 'h07, "R5 index low bits");
    wr(16'h00F1, 8'h40);
    wr(16'h00F0, 8'h00); wr(16'h00F1, 8'h0F);
    wr(16'h00F0, 8'h08); wr(16'h00F1, 8'h5A);
    chk(bU1[1], 'h3F8, "R8 base held while unlocked");
    chk(enG[1], 0, "R8 enable forced off");
    wr(16'h00F0, 8'h0F); wr(16'h00F1, 8'h00);
    chk(enR[1], 1, "R7 locked after index15 write");
    chk(bU1[1], 'h17C, "R9 uart1 base applied");
    chk(bG[1], 'h100, "R9 game base applied");
    chk(enG[1], 1, "R9 game enable applied");
    chk(iR[1], 4, "R10 rtc higher irq wins");
    chk(iU1[1], 5, "R10 uart1 irq5");
    chk(iU2[1], 7, "R10 uart2 irq7");
    chk(iL[1], 'hFF, "R10 lpt unrouted");
    rdv(16'h00F1, 1, val); chk(val, 'hFF, "R5 read after lock");
    // R4 broken sequence
    wr(16'h02FA, 8'h0F); wr(16'h03FA, 8'hF0); wr(16'h02FA, 8'h01);
    wr(16'h03FA, 8'h36); wr(16'h03FA, 8'h3C); wr(16'h02FA, 8'hC3);
    chk(enR[1], 1, "R4 mismatched step restarts");
    wr(16'h03FA, 8'hFE); wr(16'h03FA, 8'h36); wr(16'h03FA, 8'h3C); wr(16'h02FA, 8'hC0);
    chk(enR[1], 1, "R4 failed complement stays locked");
    // R3 fixed key: 0x55, 0xAA, 0x36, 0x40, 0xBF -> ports 0x100/0x101
    wr(16'h02FA, 8'h55); wr(16'h03FA, 8'hAA); wr(16'h03FA, 8'h36);
    wr(16'h03FA, 8'h40); wr(16'h02FA, 8'hBF);
    chk(enR[0], 0, "R3 fixed key unlocked");
    chk(enL[0], 0, "R8 fixed-key lpt forced off");
    wr(16'h0100, 8'h04);
    rdv(16'h0101, 1, val); chk(val, 'h5F, "R7 register kept across unlock");
    rdv(16'h0101, 0, val); chk(val, 'hFE, "R1 fixed-key reg4 default");
    wr(16'h0100, 8'h0F);
    rdv(16'h0101, 0, val); chk(val, 'h40, "R6 fixed-key index15 read");
    wr(16'h0101, 8'h00);
    chk(enL[0], 1, "R9 fixed-key lpt restored");
    chk(enU2[0], 1, "R9 fixed-key uart2 restored");
    chk(bL[0], 'h278, "R9 fixed-key lpt base");
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule